// File: doc/BRIEF.md
# Shared Timer with Per-Core Comparators

This block keeps one 64-bit up-counter that every processor core in a cluster reads as a common time base. A global prescaler sets the counting rate. Each core owns a private comparator slot with a 64-bit compare value, a 32-bit auto-increment step, three banked control bits, a sticky event flag and its own interrupt line.

Software reaches the block through a single-cycle register port. A `core_sel` input picks which core's bank the access sees. The counter, the run bit and the prescaler are shared by all cores. The compare value, the step, the flag and the banked control bits belong to the selected core. The counter may only be rewritten while the timer is stopped. A comparator with auto-increment turned on re-arms itself one period ahead after every event, which gives a periodic tick.

Top module: `shared_tick_timer`

## Requirements
- R1: While the run bit (control bit 0) is set, the counter increases by exactly one every (P+1) clock cycles, where P is the prescaler field in control bits 15:8. A 32-bit carry ripples into the high word. While the run bit is clear, the counter holds its value.
- R2: A control read (offset 0x08) returns the global run bit and prescaler ORed with the selected core's banked bits: bit 1 compare enable, bit 2 interrupt enable, bit 3 auto-increment. A control write updates the global fields for all cores and the banked bits of the selected core only.
- R3: A write to counter low (0x00) or counter high (0x04) while the timer is stopped replaces only that 32-bit half. Such a write while the timer runs leaves the counter untouched. All cores read the same counter.
- R4: When the run bit and a core's compare enable are both set and the counter is greater than or equal to that core's compare value, the core's flag (status bit 0 at offset 0x0C) is set one cycle later. The flag stays set until software clears it. It never sets while either enable is clear.
- R5: With auto-increment enabled and a nonzero step (offset 0x18), every event adds the step to the compare value. With a zero step, the compare value stays unchanged.
- R6: Each core's `irq` bit is high exactly when that core's flag is set and its banked interrupt enable is set.
- R7: Writing status with bit 0 set clears the selected core's flag. Writing status with bit 0 clear has no effect.
- R8: Compare low (0x10), compare high (0x14) and the step (0x18) are banked per core. Writing them through one core leaves every other core's values unchanged.
- R9: Reads of unmapped offsets (such as 0x1C) return zero, and writes to them change no register.
- R10: Synchronous active-low reset clears the counter, the run bit, the prescaler, and every core's banked bits, flag, compare value and step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state and counting |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Register access valid this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| core_sel | input | CORE_W | Core whose bank the access targets |
| addr | input | 5 | Byte offset in the 32-byte window, 32-bit aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr and core_sel |
| irq | output | NCORES | Per-core interrupt lines |

## Verification
The bench builds the block with two cores and an 8-bit prescaler. Two cores are the fewest that can show banking: one core's writes do not disturb the other's compare value or control bits, one core's auto-incrementing comparator runs beside another core's disabled one, and a control write from either core changes the shared run bit and prescaler. The 8-bit prescaler makes two settings testable in a short run. A ratio of 4 checks the exact counting rate. A ratio of 256 keeps the counter visibly still while the bench tries to write it during a run.

// File: rtl/stt_pkg.sv
// Package: register offsets, control bit positions and the banked
// control type shared by the timer's modules.
package stt_pkg;
    localparam logic [4:0] A_CNT_LO = 5'h00;
    localparam logic [4:0] A_CNT_HI = 5'h04;
    localparam logic [4:0] A_CTRL   = 5'h08;
    localparam logic [4:0] A_STAT   = 5'h0C;
    localparam logic [4:0] A_CMP_LO = 5'h10;
    localparam logic [4:0] A_CMP_HI = 5'h14;
    localparam logic [4:0] A_STEP   = 5'h18;

    localparam int B_RUN   = 0;
    localparam int B_CMPEN = 1;
    localparam int B_IE    = 2;
    localparam int B_AUTO  = 3;
    localparam int PRE_LSB = 8;

    typedef struct packed {
        logic auto_inc;
        logic irq_en;
        logic cmp_en;
    } bank_t;
endpackage

// File: rtl/stt_prescaler.sv
// Module: stt_prescaler
// Emits a one-cycle tick every (limit+1) cycles while run is high.
// Assumes: the divider restarts from zero whenever run is low. A limit
// lowered below the current count ends the period at once.
module stt_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] limit,
    output logic          tick
);
    logic [PW-1:0] div_q;

    assign tick = run && (div_q >= limit);

    // Purpose: count cycles within one prescaler period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_q <= '0;
        else if (tick)      div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/stt_counter.sv
// Module: stt_counter
// Shared free-running up-counter with separately writable 32-bit halves.
// Assumes: the parent blocks half writes while the timer runs, so a
// write and a tick never occur together.
module stt_counter #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [31:0]   wdata,
    output logic [CW-1:0] count
);
    localparam int HI_W = CW - 32;

    // Purpose: load a half on a write, otherwise advance on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (wr_lo) count[31:0] <= wdata;
        else if (wr_hi) count[CW-1:32] <= wdata[HI_W-1:0];
        else if (tick)  count <= count + 1'b1;
    end
endmodule

// File: rtl/stt_core_slot.sv
// Module: stt_core_slot
// One core's banked comparator: compare value, step, control bits,
// sticky flag and interrupt.
// Assumes: acc is high only for accesses aimed at this core. A software
// write to the compare value takes priority over auto-increment.
module stt_core_slot
    import stt_pkg::*;
#(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] count,
    input  logic          acc,
    input  logic          wr,
    input  logic [4:0]    addr,
    input  logic [31:0]   wdata,
    output bank_t         bank,
    output logic [CW-1:0] cmp,
    output logic [31:0]   step,
    output logic          flag,
    output logic          irq
);
    localparam int HI_W = CW - 32;

    logic hit;
    logic do_wr;
    logic clr;

    assign do_wr = acc && wr;
    assign hit   = run && bank.cmp_en && (count >= cmp);
    assign clr   = do_wr && (addr == A_STAT) && wdata[0];
    assign irq   = flag && bank.irq_en;

    // Purpose: hold the banked control bits and the step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank <= '0;
            step <= '0;
        end else if (do_wr) begin
            if (addr == A_CTRL) begin
                bank.cmp_en   <= wdata[B_CMPEN];
                bank.irq_en   <= wdata[B_IE];
                bank.auto_inc <= wdata[B_AUTO];
            end
            if (addr == A_STEP) step <= wdata;
        end
    end

    // Purpose: load the compare value or advance it after an event.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cmp <= '0;
        else if (do_wr && addr == A_CMP_LO)      cmp[31:0] <= wdata;
        else if (do_wr && addr == A_CMP_HI)      cmp[CW-1:32] <= wdata[HI_W-1:0];
        else if (hit && bank.auto_inc && step != '0)
                                                 cmp <= cmp + CW'(step);
    end

    // Purpose: sticky event flag, cleared by writing one; an event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= (flag && !clr) || hit;
    end
endmodule

// File: rtl/shared_tick_timer.sv
// Module: shared_tick_timer
// Top: global run bit and prescaler, shared counter, one comparator
// slot per core, and the combinational read mux.
// Assumes: single-cycle 32-bit accesses only. A core_sel beyond NCORES-1
// reaches the global fields but no bank.
module shared_tick_timer
    import stt_pkg::*;
#(
    parameter int NCORES  = 2,
    parameter int PRESC_W = 8,
    parameter int CNT_W   = 64,
    localparam int CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [CORE_W-1:0] core_sel,
    input  logic [4:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NCORES-1:0] irq
);
    logic               run_q;
    logic [PRESC_W-1:0] presc_q;
    logic               tick;
    logic [CNT_W-1:0]   count_q;
    logic               cnt_wr_lo;
    logic               cnt_wr_hi;

    bank_t              bank_a [NCORES];
    logic [CNT_W-1:0]   cmp_a  [NCORES];
    logic [31:0]        step_a [NCORES];
    logic [NCORES-1:0]  stat_vec;

    // Purpose: global run bit and prescaler, written by any core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            presc_q <= '0;
        end else if (req && wr && addr == A_CTRL) begin
            run_q   <= wdata[B_RUN];
            presc_q <= wdata[PRE_LSB +: PRESC_W];
        end
    end

    assign cnt_wr_lo = req && wr && !run_q && (addr == A_CNT_LO);
    assign cnt_wr_hi = req && wr && !run_q && (addr == A_CNT_HI);

    stt_prescaler #(.PW(PRESC_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q), .limit(presc_q), .tick(tick)
    );

    stt_counter #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lo(cnt_wr_lo),
        .wr_hi(cnt_wr_hi), .wdata(wdata), .count(count_q)
    );

    for (genvar g = 0; g < NCORES; g++) begin : g_slot
        logic acc_g;
        assign acc_g = req && (core_sel == CORE_W'(g));
        stt_core_slot #(.CW(CNT_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .run(run_q), .count(count_q),
            .acc(acc_g), .wr(wr), .addr(addr), .wdata(wdata),
            .bank(bank_a[g]), .cmp(cmp_a[g]), .step(step_a[g]),
            .flag(stat_vec[g]), .irq(irq[g])
        );
    end

    // Purpose: select the addressed register for the requesting core.
    always_comb begin
        bank_t            pb;
        logic [CNT_W-1:0] pc;
        logic [31:0]      ps;
        logic             pf;
        pb = '0;
        pc = '0;
        ps = '0;
        pf = 1'b0;
        for (int i = 0; i < NCORES; i++) begin
            if (core_sel == CORE_W'(i)) begin
                pb = bank_a[i];
                pc = cmp_a[i];
                ps = step_a[i];
                pf = stat_vec[i];
            end
        end
        rdata = '0;
        case (addr)
            A_CNT_LO: rdata = count_q[31:0];
            A_CNT_HI: rdata = 32'(count_q >> 32);
            A_CTRL: begin
                rdata[PRE_LSB +: PRESC_W] = presc_q;
                rdata[B_RUN]   = run_q;
                rdata[B_CMPEN] = pb.cmp_en;
                rdata[B_IE]    = pb.irq_en;
                rdata[B_AUTO]  = pb.auto_inc;
            end
            A_STAT:   rdata[0] = pf;
            A_CMP_LO: rdata = pc[31:0];
            A_CMP_HI: rdata = 32'(pc >> 32);
            A_STEP:   rdata = ps;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/stt_checker.sv
// Module: stt_checker
// Property checks on the timer's ports and key state, bound to the top.
// Assumes: synchronous active-low reset held from time zero.
module stt_checker #(
    parameter int NCORES = 2,
    parameter int CORE_W = 1,
    parameter int CNT_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              wr,
    input logic [CORE_W-1:0] core_sel,
    input logic [4:0]        addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [NCORES-1:0] irq,
    input logic              run_q,
    input logic [CNT_W-1:0]  count_q,
    input logic [NCORES-1:0] stat_vec
);
    logic cnt_wr;
    assign cnt_wr = req && wr && (addr == 5'h00 || addr == 5'h04);

    // R1: a running counter moves by at most one per cycle
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> (count_q - $past(count_q)) <= 1);

    // R1: a stopped, unwritten counter holds
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !cnt_wr) |=> count_q == $past(count_q));

    // R3: a write to the low half while stopped loads it
    a_r3_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && req && wr && addr == 5'h00) |=> count_q[31:0] == $past(wdata));

    // R9: unmapped offset reads as zero
    a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && addr == 5'h1C) |-> rdata == 32'h0);

    for (genvar i = 0; i < NCORES; i++) begin : g_core
        logic clr_i;
        assign clr_i = req && wr && addr == 5'h0C && wdata[0] &&
                       core_sel == CORE_W'(i);

        // R4: the flag is sticky unless cleared
        a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_vec[i] && !clr_i) |=> stat_vec[i]);

        // R4: the flag only sets while the timer runs
        a_r4_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
            !stat_vec[i] |=> (!stat_vec[i] || $past(run_q)));

        // R6: an interrupt implies a set flag
        a_r6_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> stat_vec[i]);
    end
endmodule

bind shared_tick_timer stt_checker #(
    .NCORES(NCORES), .CORE_W(CORE_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .core_sel(core_sel),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .run_q(run_q),
    .count_q(count_q), .stat_vec(stat_vec)
);

// File: tb/shared_tick_timer_bench.sv
`timescale 1ns/1ps
// Bench: register vector table followed by directed timing tests.
module shared_tick_timer_bench;
    localparam int NC = 2;
    localparam int CW = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          wr = 1'b0;
    logic [CW-1:0] core_sel = '0;
    logic [4:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NC-1:0] irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shared_tick_timer #(.NCORES(NC), .PRESC_W(8), .CNT_W(64)) u_shared_tick_timer (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .core_sel(core_sel),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic        is_rd;
        logic [1:0]  core;
        logic [4:0]  addr;
        logic [31:0] val;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd0, 5'h00, 32'hAABBCCDD, 4'd3},  // R3 load low while stopped
        '{1'b1, 2'd0, 5'h00, 32'hAABBCCDD, 4'd3},
        '{1'b0, 2'd0, 5'h04, 32'h11223344, 4'd3},  // R3 high half only
        '{1'b1, 2'd1, 5'h04, 32'h11223344, 4'd3},  // R3 shared counter
        '{1'b1, 2'd1, 5'h00, 32'hAABBCCDD, 4'd3},
        '{1'b0, 2'd0, 5'h10, 32'h00000123, 4'd8},  // R8 compare halves
        '{1'b0, 2'd0, 5'h14, 32'h00000005, 4'd8},
        '{1'b1, 2'd0, 5'h10, 32'h00000123, 4'd8},
        '{1'b1, 2'd0, 5'h14, 32'h00000005, 4'd8},
        '{1'b1, 2'd1, 5'h10, 32'h00000000, 4'd8},  // R8 other core untouched
        '{1'b0, 2'd1, 5'h18, 32'h00000077, 4'd8},
        '{1'b1, 2'd1, 5'h18, 32'h00000077, 4'd8},
        '{1'b1, 2'd0, 5'h18, 32'h00000000, 4'd8},
        '{1'b0, 2'd0, 5'h08, 32'h0000AB06, 4'd2},  // R2 split write
        '{1'b1, 2'd0, 5'h08, 32'h0000AB06, 4'd2},
        '{1'b1, 2'd1, 5'h08, 32'h0000AB00, 4'd2},  // R2 global part shared
        '{1'b0, 2'd1, 5'h08, 32'h00001208, 4'd2},
        '{1'b1, 2'd1, 5'h08, 32'h00001208, 4'd2},
        '{1'b1, 2'd0, 5'h08, 32'h00001206, 4'd2},  // R2 banked kept
        '{1'b0, 2'd0, 5'h1C, 32'hFFFFFFFF, 4'd9},  // R9 unmapped write
        '{1'b1, 2'd0, 5'h1C, 32'h00000000, 4'd9},
        '{1'b1, 2'd0, 5'h10, 32'h00000123, 4'd9},
        '{1'b0, 2'd0, 5'h0C, 32'h00000001, 4'd7},  // R7 clear of clear flag
        '{1'b1, 2'd0, 5'h0C, 32'h00000000, 4'd7},
        '{1'b0, 2'd0, 5'h08, 32'h00000000, 4'd2},
        '{1'b0, 2'd1, 5'h08, 32'h00000000, 4'd2}
    };

    task automatic check(input int rq, input logic [31:0] got,
                         input logic [31:0] exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, got, exp);
        end
    endtask

    task automatic do_wr(input int c, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; wr = 1'b1; core_sel = CW'(c); addr = a; wdata = d;
        @(posedge clk);
        #1;
        req = 1'b0; wr = 1'b0;
    endtask

    task automatic chk_rd(input int c, input logic [4:0] a,
                          input logic [31:0] exp, input int rq, input string what);
        @(negedge clk);
        req = 1'b1; wr = 1'b0; core_sel = CW'(c); addr = a;
        #1;
        check(rq, rdata, exp, what);
        req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state
        chk_rd(0, 5'h00, 32'h0, 10, "R10 counter low after reset");
        chk_rd(0, 5'h08, 32'h0, 10, "R10 control after reset");
        chk_rd(1, 5'h10, 32'h0, 10, "R10 compare after reset");
        check(10, 32'(irq), 32'h0, "R10 irq after reset");

        // Vector table: register access with the timer stopped
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].is_rd)
                chk_rd(int'(TBL[i].core), TBL[i].addr, TBL[i].val, int'(TBL[i].rq), "table read");
            else
                do_wr(int'(TBL[i].core), TBL[i].addr, TBL[i].val);
        end

        // R1: prescaler 3 -> one step per 4 cycles
        do_wr(0, 5'h00, 32'h0);
        do_wr(0, 5'h04, 32'h0);
        do_wr(0, 5'h08, 32'h0301);
        repeat (20) @(posedge clk);
        chk_rd(0, 5'h00, 32'd5, 1, "R1 count after 20 cycles at ratio 4");
        do_wr(0, 5'h08, 32'h0);
        repeat (10) @(posedge clk);
        chk_rd(1, 5'h00, 32'd5, 1, "R1 stopped counter holds");

        // R3: writes ignored while running (prescaler 255 keeps count still)
        do_wr(0, 5'h00, 32'h50);
        do_wr(0, 5'h08, 32'hFF01);
        do_wr(0, 5'h00, 32'h1234);
        do_wr(1, 5'h04, 32'h9);
        chk_rd(0, 5'h00, 32'h50, 3, "R3 low write ignored while running");
        chk_rd(0, 5'h04, 32'h0, 3, "R3 high write ignored while running");
        do_wr(0, 5'h08, 32'h0);

        // R4/R6/R7: core0 compare at 10, prescaler 0
        do_wr(0, 5'h00, 32'h0);
        do_wr(0, 5'h10, 32'd10);
        do_wr(0, 5'h14, 32'h0);
        do_wr(0, 5'h08, 32'h0007);
        repeat (10) @(posedge clk);
        chk_rd(0, 5'h0C, 32'h0, 4, "R4 no event before count reaches compare");
        @(posedge clk);
        chk_rd(0, 5'h0C, 32'h1, 4, "R4 event one cycle after count equals compare");
        check(6, 32'(irq), 32'h1, "R6 irq core0 only");
        repeat (5) @(posedge clk);
        chk_rd(0, 5'h0C, 32'h1, 4, "R4 flag sticky");
        do_wr(0, 5'h08, 32'h0003);
        #2 check(6, 32'(irq[0]), 32'h0, "R6 irq off with enable clear");
        chk_rd(0, 5'h0C, 32'h1, 6, "R6 flag kept while masked");
        do_wr(0, 5'h08, 32'h0001);
        do_wr(0, 5'h0C, 32'h0);
        chk_rd(0, 5'h0C, 32'h1, 7, "R7 writing zero keeps flag");
        do_wr(0, 5'h0C, 32'h1);
        chk_rd(0, 5'h0C, 32'h0, 7, "R7 writing one clears flag");
        repeat (3) @(posedge clk);
        chk_rd(0, 5'h0C, 32'h0, 4, "R4 no event with compare disabled");
        chk_rd(1, 5'h0C, 32'h0, 8, "R8 core1 flag untouched");

        // R5: core1 auto-increment, compare 4 step 6
        do_wr(1, 5'h08, 32'h0);
        do_wr(1, 5'h00, 32'h0);
        do_wr(1, 5'h04, 32'h0);
        do_wr(1, 5'h10, 32'd4);
        do_wr(1, 5'h18, 32'd6);
        do_wr(1, 5'h08, 32'h000B);
        repeat (5) @(posedge clk);
        chk_rd(1, 5'h10, 32'd10, 5, "R5 compare advanced by step after first event");
        chk_rd(1, 5'h0C, 32'h1, 5, "R5 flag set by periodic event");
        repeat (5) @(posedge clk);
        chk_rd(1, 5'h10, 32'd16, 5, "R5 compare advanced again one period later");
        check(6, 32'(irq), 32'h0, "R6 no irq with interrupt enable clear");

        // R5: zero step leaves compare unchanged (core0, running)
        do_wr(0, 5'h10, 32'd20);
        do_wr(0, 5'h08, 32'h000B);
        repeat (25) @(posedge clk);
        chk_rd(0, 5'h10, 32'd20, 5, "R5 zero step keeps compare");
        chk_rd(0, 5'h0C, 32'h1, 4, "R4 event on greater-or-equal");

        // R1: carry into high word
        do_wr(0, 5'h08, 32'h0);
        do_wr(1, 5'h08, 32'h0);
        do_wr(0, 5'h00, 32'hFFFFFFFF);
        do_wr(0, 5'h04, 32'h0);
        do_wr(0, 5'h08, 32'h0001);
        repeat (2) @(posedge clk);
        chk_rd(0, 5'h00, 32'h1, 1, "R1 low word after carry");
        chk_rd(0, 5'h04, 32'h1, 1, "R1 high word after carry");

        // R10: reset while running
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk_rd(0, 5'h00, 32'h0, 10, "R10 counter cleared");
        chk_rd(0, 5'h08, 32'h0, 10, "R10 control cleared");
        chk_rd(1, 5'h10, 32'h0, 10, "R10 compare cleared");
        chk_rd(1, 5'h18, 32'h0, 10, "R10 step cleared");
        chk_rd(0, 5'h0C, 32'h0, 10, "R10 flag cleared");
        check(10, 32'(irq), 32'h0, "R10 irq cleared");

        finish_run();
    end
endmodule